// File: doc/BRIEF.md
# GPIO Bank Controller

This block controls one bank of up to 32 general-purpose pins through a single-cycle 32-bit register bus. Each pin has an output latch, an output-enable bit and a synchronized input. Software selects the direction and input inversion of each pin. It changes the output latch by loading it whole, or by writing masks to separate set, clear and toggle offsets. A write to these offsets touches only the bits written as 1, so software needs no read-modify-write to change one line.

Every input passes through a synchronizer. It is then XORed with its polarity bit, and the result feeds both the data readback and an edge detector. A rising or falling edge on a pin marks that pin's interrupt status bit when the matching per-direction enable is set. An edge-status register records whether the latest enabled edge went up or down. Software clears status bits by writing 1 to them. The combined interrupt output stays high while any status bit is set.

There is no control state machine. The only enumerated state is the operation applied to the output latch in each cycle: hold, load, set, clear or toggle. This operation is decoded from the bus write.

Top module: `gpio_bank`

## Requirements
- R1: After reset all registers are zero, including polarity at offset 0x28. gpio_o, gpio_oe and irq are 0.
- R2: The direction register at offset 0x24 drives gpio_oe one cycle after the write: bit 1 means output and bit 0 means input. The register reads back as written.
- R3: A write to offset 0x2C drives high every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to offset 0x30 drives low every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R5: A write to offset 0x34 inverts every latch bit written as 1 and leaves the bits written as 0 unchanged.
- R6: A write to offset 0x20 loads the whole latch. A read of 0x20 returns the latch for output pins, and for input pins the polarity-adjusted input. A pin change becomes visible in that read after two clock edges.
- R7: Polarity bit 1 at offset 0x28 inverts the pin level seen by the data read and by the edge detector. Bit 0 passes the level unchanged.
- R8: The latch can be set while the pin is still an input. The first cycle with gpio_oe high then already shows the preset value on gpio_o.
- R9: An interrupt status bit (offset 0x00) is set three clock edges after a pin change in two cases. One is a rising adjusted level with the rising enable (offset 0x08) set. The other is a falling adjusted level with the falling enable (offset 0x0C) set. An edge whose direction is not enabled sets nothing.
- R10: The edge-status register at offset 0x04 is read-only. It records 1 for an enabled rising edge and 0 for an enabled falling edge.
- R11: Writing 1 to a bit of offset 0x00 clears that status bit, and status bits are otherwise sticky. An enabled edge that lands in the same cycle as the clear keeps the bit set.
- R12: irq is the OR of all interrupt status bits.
- R13: Reads return zero when rd_en is high and the offset is unmapped, misaligned or one of the write-only offsets 0x2C, 0x30 and 0x34. Writes to unmapped offsets and to the read-only offset 0x04 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read enable; rd_data is combinational from addr |
| rd_data | output | 32 | Read data, zero when rd_en is low |
| gpio_i | input | NPINS | Pin input levels (asynchronous) |
| gpio_o | output | NPINS | Output latch |
| gpio_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The latch is driven with overlapping set, clear and toggle masks. A mask that is wrongly applied to bits written as 0, or that swaps the set and clear roles, then shows up as a wrong bit pattern rather than one that happens to match. Input patterns are presented with mixed directions and with polarity on and then off, which separates the output-latch readback from the adjusted input readback. Single pins are driven through rising and falling transitions with each enable on or off, which exposes enable swaps and an edge status recorded with the wrong sense. A fall timed to meet a clear write in the same cycle tells whether a new edge wins against the clear. Unmapped, misaligned and read-only accesses are mixed in to show that the decode rejects them.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W = 32;

    localparam logic [7:0] OFF_IRQ_STAT  = 8'h00;
    localparam logic [7:0] OFF_EDGE_STAT = 8'h04;
    localparam logic [7:0] OFF_RISE_EN   = 8'h08;
    localparam logic [7:0] OFF_FALL_EN   = 8'h0C;
    localparam logic [7:0] OFF_DATA      = 8'h20;
    localparam logic [7:0] OFF_DIR       = 8'h24;
    localparam logic [7:0] OFF_POL       = 8'h28;
    localparam logic [7:0] OFF_SET       = 8'h2C;
    localparam logic [7:0] OFF_CLR       = 8'h30;
    localparam logic [7:0] OFF_TGL       = 8'h34;

    typedef enum logic [2:0] {
        LAT_HOLD,
        LAT_LOAD,
        LAT_SET,
        LAT_CLR,
        LAT_TGL
    } lat_op_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] level_o
);

    logic [NPINS-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign level_o = stage_q[STAGES-1] ^ pol;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status_o,
    output logic [NPINS-1:0] edge_o
);

    logic [NPINS-1:0] prev_q, status_q, edge_q;
    logic [NPINS-1:0] rise, fall, hit;

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
    assign hit  = (rise & rise_en) | (fall & fall_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            status_q <= '0;
            edge_q   <= '0;
        end else begin
            prev_q   <= level;
            status_q <= (status_q & ~clr_mask) | hit;
            edge_q   <= (edge_q & ~hit) | (rise & hit);
        end
    end

    assign status_o = status_q;
    assign edge_o   = edge_q;

    AST_EDGE_WINS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((status_q & $past(hit)) == $past(hit)))
        else $error("enabled edge lost"); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> (($past(status_q) & ~status_q) == '0))
        else $error("status dropped without clear"); // R11

    AST_RISE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & rise_en)) |=> ((edge_q & $past(rise & rise_en)) == $past(rise & rise_en)))
        else $error("rising edge not recorded"); // R10

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lat_op_e          op,
    input  logic [NPINS-1:0] wmask,
    output logic [NPINS-1:0] lat_o
);

    logic [NPINS-1:0] lat_q, lat_d;

    always_comb begin
        lat_d = lat_q;
        unique case (op)
            LAT_HOLD: lat_d = lat_q;
            LAT_LOAD: lat_d = wmask;
            LAT_SET:  lat_d = lat_q | wmask;
            LAT_CLR:  lat_d = lat_q & ~wmask;
            LAT_TGL:  lat_d = lat_q ^ wmask;
            default:  lat_d = lat_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign lat_o = lat_q;

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LAT_SET) |=> ((lat_q & $past(wmask)) == $past(wmask)))
        else $error("set mask not applied"); // R3

    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LAT_CLR) |=> ((lat_q & $past(wmask)) == '0))
        else $error("clear mask not applied"); // R4

    AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LAT_TGL) |=> (lat_q == ($past(lat_q) ^ $past(wmask))))
        else $error("toggle mask not applied"); // R5

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic [NPINS-1:0]  gpio_i,
    output logic [NPINS-1:0]  gpio_o,
    output logic [NPINS-1:0]  gpio_oe,
    output logic              irq
);

    logic [NPINS-1:0] dir_q, pol_q, rise_en_q, fall_en_q;
    logic [NPINS-1:0] level, status, edge_rec, latch, clr_mask, wmask;
    logic sel_irq, sel_edge, sel_rise, sel_fall, sel_data, sel_dir, sel_pol;
    logic sel_set, sel_clr, sel_tgl;
    lat_op_e lat_op;

    assign wmask    = wr_data[NPINS-1:0];
    assign sel_irq  = (addr == ADDR_W'(OFF_IRQ_STAT));
    assign sel_edge = (addr == ADDR_W'(OFF_EDGE_STAT));
    assign sel_rise = (addr == ADDR_W'(OFF_RISE_EN));
    assign sel_fall = (addr == ADDR_W'(OFF_FALL_EN));
    assign sel_data = (addr == ADDR_W'(OFF_DATA));
    assign sel_dir  = (addr == ADDR_W'(OFF_DIR));
    assign sel_pol  = (addr == ADDR_W'(OFF_POL));
    assign sel_set  = (addr == ADDR_W'(OFF_SET));
    assign sel_clr  = (addr == ADDR_W'(OFF_CLR));
    assign sel_tgl  = (addr == ADDR_W'(OFF_TGL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q     <= '0;
            pol_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en) begin
            if (sel_dir)  dir_q     <= wmask;
            if (sel_pol)  pol_q     <= wmask;
            if (sel_rise) rise_en_q <= wmask;
            if (sel_fall) fall_en_q <= wmask;
        end
    end

    always_comb begin
        lat_op = LAT_HOLD;
        if (wr_en) begin
            if (sel_data)     lat_op = LAT_LOAD;
            else if (sel_set) lat_op = LAT_SET;
            else if (sel_clr) lat_op = LAT_CLR;
            else if (sel_tgl) lat_op = LAT_TGL;
        end
    end

    assign clr_mask = (wr_en && sel_irq) ? wmask : '0;

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (gpio_i),
        .pol     (pol_q),
        .level_o (level)
    );

    gpio_edge_irq #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .clr_mask (clr_mask),
        .status_o (status),
        .edge_o   (edge_rec)
    );

    gpio_out_latch #(.NPINS(NPINS)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (lat_op),
        .wmask (wmask),
        .lat_o (latch)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (sel_irq)       rd_data = DATA_W'(status);
            else if (sel_edge) rd_data = DATA_W'(edge_rec);
            else if (sel_rise) rd_data = DATA_W'(rise_en_q);
            else if (sel_fall) rd_data = DATA_W'(fall_en_q);
            else if (sel_data) rd_data = DATA_W'((latch & dir_q) | (level & ~dir_q));
            else if (sel_dir)  rd_data = DATA_W'(dir_q);
            else if (sel_pol)  rd_data = DATA_W'(pol_q);
        end
    end

    assign gpio_o  = latch;
    assign gpio_oe = dir_q;
    assign irq     = |status;

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_dir) |=> (gpio_oe == $past(wmask)))
        else $error("direction write not on gpio_oe"); // R2

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && sel_irq)) |=> irq)
        else $error("irq dropped without clear"); // R12

endmodule

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [N-1:0] gpio_i = '0;
    logic [N-1:0] gpio_o, gpio_oe;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_tag = "R13";

    // reference model state
    logic [31:0] m_s1, m_s2, m_prev, m_lat, m_dir, m_pol, m_ren, m_fen, m_ist, m_est;

    always #4 clk = ~clk;

    gpio_bank dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .gpio_i(gpio_i), .gpio_o(gpio_o),
        .gpio_oe(gpio_oe), .irq(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_lat = 0; m_dir = 0;
            m_pol = 0; m_ren = 0; m_fen = 0; m_ist = 0; m_est = 0;
        end else begin
            logic [31:0] lv, up, dn, hit, clr;
            lv  = m_s2 ^ m_pol;
            up  = lv & ~m_prev;
            dn  = ~lv & m_prev;
            hit = (up & m_ren) | (dn & m_fen);
            clr = (wr_en && addr == 8'h00) ? wr_data : 32'h0;
            m_ist  = (m_ist & ~clr) | hit;
            m_est  = (m_est & ~hit) | (up & hit);
            m_prev = lv;
            m_s2   = m_s1;
            m_s1   = gpio_i;
            if (wr_en) begin
                case (addr)
                    8'h08: m_ren = wr_data;
                    8'h0C: m_fen = wr_data;
                    8'h20: m_lat = wr_data;
                    8'h24: m_dir = wr_data;
                    8'h28: m_pol = wr_data;
                    8'h2C: m_lat = m_lat | wr_data;
                    8'h30: m_lat = m_lat & ~wr_data;
                    8'h34: m_lat = m_lat ^ wr_data;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        case (a)
            8'h00: return m_ist;
            8'h04: return m_est;
            8'h08: return m_ren;
            8'h0C: return m_fen;
            8'h20: return (m_lat & m_dir) | ((m_s2 ^ m_pol) & ~m_dir);
            8'h24: return m_dir;
            8'h28: return m_pol;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R5 gpio_o vs model", gpio_o, m_lat);
            chk("R2 gpio_oe vs model", gpio_oe, m_dir);
            chk("R12 irq vs model", {31'h0, irq}, {31'h0, |m_ist});
            if (rd_en) chk({cur_tag, " rd_data vs model"}, rd_data, model_rd(addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b0; addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cur_tag = tag; addr = a; rd_en = 1'b1;
        #2;
        chk(tag, rd_data, exp);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 gpio_o at reset", gpio_o, 0);
        chk("R1 gpio_oe at reset", gpio_oe, 0);
        chk("R1 irq at reset", {31'h0, irq}, 0);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h28, 32'h0, "R1 polarity reset");
        rd(8'h24, 32'h0, "R1 direction reset");

        // R2 direction
        wr(8'h24, 32'h0000_FFFF);
        chk("R2 gpio_oe after dir write", gpio_oe, 32'h0000_FFFF);
        rd(8'h24, 32'h0000_FFFF, "R2 dir readback");

        // R3/R4/R5 latch masks
        wr(8'h2C, 32'h0000_00F0);
        chk("R3 set F0", gpio_o, 32'h0000_00F0);
        wr(8'h2C, 32'h0000_000F);
        chk("R3 set keeps others", gpio_o, 32'h0000_00FF);
        wr(8'h30, 32'h0000_0030);
        chk("R4 clear", gpio_o, 32'h0000_00CF);
        wr(8'h34, 32'h0000_0101);
        chk("R5 toggle", gpio_o, 32'h0000_01CE);

        // R8 preset before enabling
        wr(8'h2C, 32'h0010_0000);
        chk("R8 latch preset while input", gpio_o & 32'h0010_0000, 32'h0010_0000);
        chk("R8 pin still input", gpio_oe & 32'h0010_0000, 32'h0);
        wr(8'h24, 32'h0010_FFFF);
        chk("R8 first enabled cycle shows preset", gpio_o & gpio_oe & 32'h0010_0000, 32'h0010_0000);

        // R6 data read of inputs with synchronizer latency
        @(negedge clk); gpio_i = 32'h0A00_0000;
        @(negedge clk); cur_tag = "R6"; addr = 8'h20; rd_en = 1'b1;
        #2; chk("R6 data before 2 edges", rd_data & 32'h0F00_0000, 32'h0);
        @(negedge clk); #2;
        chk("R6 data after 2 edges", rd_data & 32'h0F00_0000, 32'h0A00_0000);
        rd(8'h20, 32'h0A10_01CE, "R6 mixed read");
        wr(8'h20, 32'h0000_1234);
        chk("R6 data write loads latch", gpio_o, 32'h0000_1234);

        // R7 polarity
        wr(8'h28, 32'h0F00_0000);
        rd(8'h20, 32'h0500_1234, "R7 inverted input read");
        cyc(2);
        chk("R9 no irq with edges disabled", {31'h0, irq}, 0);
        wr(8'h28, 32'h0);
        cyc(3);

        // R9 / R10 / R12 rising edge on pin 28
        wr(8'h08, 32'h1000_0000);
        @(negedge clk); gpio_i = 32'h1A00_0000;
        cyc(2);
        chk("R9 no status before third edge", {31'h0, irq}, 0);
        cyc(1);
        chk("R12 irq after enabled rise", {31'h0, irq}, 1);
        rd(8'h00, 32'h1000_0000, "R9 status bit 28");
        rd(8'h04, 32'h1000_0000, "R10 edge status rising");

        // R11 clear, R9 disabled falling edge
        wr(8'h00, 32'h1000_0000);
        chk("R11 clear drops irq", {31'h0, irq}, 0);
        @(negedge clk); gpio_i = 32'h0A00_0000;
        cyc(4);
        chk("R9 disabled fall sets nothing", {31'h0, irq}, 0);

        // R11 same-cycle clear and new edge
        wr(8'h0C, 32'h1000_0000);
        @(negedge clk); gpio_i = 32'h1A00_0000;
        cyc(4);
        chk("R9 rise again", {31'h0, irq}, 1);
        @(negedge clk); gpio_i = 32'h0A00_0000;
        @(negedge clk);
        @(negedge clk);
        rd_en = 1'b0; addr = 8'h00; wr_data = 32'h1000_0000; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        chk("R11 edge wins over clear", {31'h0, irq}, 1);
        rd(8'h04, 32'h0, "R10 edge status falling");

        // R13 unmapped, misaligned, write-only, read-only
        rd(8'h10, 32'h0, "R13 unmapped read");
        rd(8'h05, 32'h0, "R13 misaligned read");
        rd(8'h2C, 32'h0, "R13 write-only read");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R13 read-only write ignored");
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h24, 32'h0010_FFFF, "R13 unmapped write ignored");
        chk("R13 latch untouched", gpio_o, 32'h0000_1234);

        cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule